// File: doc/BRIEF.md
# Compressed Bit-Field Instruction Expander

This block sits in an instruction decode stage and looks at 32-bit instruction words in the custom-3 major opcode. It recognizes the compact encoding of the bit-field extract-and-place operation and of its complement variant. For each recognized word it produces the full operation fields: destination register, first source register, second source register, extract start position, field length, placement offset and a complement flag.

The immediate bits are split across two areas of the word. Register numbers are 3-bit compact indices that are offset by 8. A single bit chooses the second source as either the zero register or the destination register. The parameter `XLEN` (32 or 64) selects which length and range rules apply.

Each word that arrives with `valid_i` produces a registered result one cycle later. That result carries a match flag and an illegal flag. A word that fails a length, range or reserved-space rule raises the illegal flag instead of the match flag. Words with any other opcode raise neither flag.

Top module: `cbf_expander`

## Requirements
- R1: A word is recognized only when bits [6:0] equal 7'b1111011. For any other opcode, `match_o` and `illegal_o` are both low in the result.
- R2: A result appears in the cycle after `valid_i` is sampled high, and `valid_o` is high with it. When `valid_i` was low, `valid_o`, `match_o` and `illegal_o` are all low.
- R3: `rd_o` is bits [9:7] plus 8, and `rs1_o` is bits [17:15] plus 8.
- R4: When bit 10 is 0, `rs2_o` is 0. When bit 10 is 1, `rs2_o` equals `rd_o`.
- R5: The start position is {bit14, bit13, bits[27:24]}. The length code is {bit12, bits[31:28]}. The placement offset is bits [23:18].
- R6: `cmpl_o` equals bit 11.
- R7: A length code of 0 gives `len_o` = 32 when XLEN=64. It is illegal when XLEN=32.
- R8: A word with bits [14:12] = 3'b111 and any of bits [31:24] set is illegal under both XLEN settings.
- R9: A word is illegal when start+len > XLEN or dest+len > XLEN. A sum equal to XLEN is legal.
- R10: `match_o` and `illegal_o` are never high together.
- R11: While `rst_ni` is low, all outputs are 0, even when `valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word strobe |
| instr_i | input | 32 | Instruction word |
| valid_o | output | 1 | Registered result valid |
| match_o | output | 1 | Legal compact bit-field word recognized |
| illegal_o | output | 1 | Recognized opcode but reserved or out-of-range encoding |
| rd_o | output | 5 | Expanded destination register |
| rs1_o | output | 5 | Expanded first source register |
| rs2_o | output | 5 | Expanded second source register |
| start_o | output | 6 | Extract start bit position |
| len_o | output | 6 | Field length, 1 to 32 |
| dest_o | output | 6 | Placement offset |
| cmpl_o | output | 1 | Complement variant selected |

## Verification
The bench runs the same words through a 64-bit and a 32-bit instance. This shows the zero length code expanding to 32 on one instance and being rejected on the other; a design that decoded the code literally would report a length of 0 or accept it on RV32. Words with start or offset plus length exactly at XLEN, and one past it, expose an off-by-one bound check. Scattered immediate bits (start[5], start[4], len[4]) are set one at a time, which catches a swapped or dropped bit. The funct3=111 reserved pattern, a wrong opcode and back-to-back strobes catch a missing reserved check, a false match, and a pipeline that holds or loses a result.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  localparam logic [6:0] CBF_OPCODE  = 7'b1111011;
  localparam logic [4:0] CBF_REG_OFS = 5'd8;

  typedef struct packed {
    logic       match;
    logic       illegal;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic [5:0] start;
    logic [5:0] len;
    logic [5:0] dest;
    logic       cmpl;
  } cbf_op_t;
endpackage

// File: rtl/cbf_unpack.sv
module cbf_unpack
  import cbf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0] instr_i,
  output logic [4:0]  rd_o,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic [5:0]  start_o,
  output logic [5:0]  len_o,
  output logic [5:0]  dest_o,
  output logic        cmpl_o,
  output logic        len_zero_o
);
  logic [4:0] len_code;

  assign rd_o     = {2'b00, instr_i[9:7]} + CBF_REG_OFS;
  assign rs1_o    = {2'b00, instr_i[17:15]} + CBF_REG_OFS;
  assign rs2_o    = instr_i[10] ? rd_o : 5'd0;
  assign start_o  = {instr_i[14], instr_i[13], instr_i[27:24]};
  assign len_code = {instr_i[12], instr_i[31:28]};
  assign dest_o   = instr_i[23:18];
  assign cmpl_o   = instr_i[11];
  assign len_zero_o = (len_code == 5'd0);

  // Zero length code: 32 on the wide variant, left as 0 (flagged) on the narrow one
  generate
    if (XLEN == 64) begin : g_rv64
      assign len_o = len_zero_o ? 6'd32 : {1'b0, len_code};
    end else begin : g_rv32
      assign len_o = {1'b0, len_code};
    end
  endgenerate
endmodule

// File: rtl/cbf_legal.sv
module cbf_legal
  import cbf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0] instr_i,
  input  logic [5:0]  start_i,
  input  logic [5:0]  len_i,
  input  logic [5:0]  dest_i,
  input  logic        len_zero_i,
  output logic        opc_hit_o,
  output logic        reserved_o
);
  localparam logic [7:0] LIMIT    = 8'(XLEN);
  localparam logic       ZERO_RSV = (XLEN == 32);

  logic [7:0] start_end;
  logic [7:0] dest_end;
  logic       brown_rsv;
  logic       range_rsv;

  assign opc_hit_o = (instr_i[6:0] == CBF_OPCODE);
  assign start_end = {2'b00, start_i} + {2'b00, len_i};
  assign dest_end  = {2'b00, dest_i} + {2'b00, len_i};
  assign brown_rsv = (&instr_i[14:12]) && (|instr_i[31:24]);
  assign range_rsv = (start_end > LIMIT) || (dest_end > LIMIT);
  assign reserved_o = brown_rsv || range_rsv || (ZERO_RSV && len_zero_i);
endmodule

// File: rtl/cbf_out_reg.sv
module cbf_out_reg
  import cbf_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    valid_i,
  input  cbf_op_t op_i,
  output logic    valid_o,
  output cbf_op_t op_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      op_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        op_o <= op_i;
      end else begin
        op_o.match   <= 1'b0;
        op_o.illegal <= 1'b0;
      end
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!op_o.match && !op_o.illegal));
endmodule

// File: rtl/cbf_expander.sv
module cbf_expander
  import cbf_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  output logic        valid_o,
  output logic        match_o,
  output logic        illegal_o,
  output logic [4:0]  rd_o,
  output logic [4:0]  rs1_o,
  output logic [4:0]  rs2_o,
  output logic [5:0]  start_o,
  output logic [5:0]  len_o,
  output logic [5:0]  dest_o,
  output logic        cmpl_o
);
  localparam logic [7:0] LIMIT = 8'(XLEN);

  initial assert (XLEN == 32 || XLEN == 64);

  cbf_op_t op_d;
  cbf_op_t op_q;
  logic    len_zero;
  logic    opc_hit;
  logic    reserved;

  cbf_unpack #(.XLEN(XLEN)) u_unpack (
    .instr_i    (instr_i),
    .rd_o       (op_d.rd),
    .rs1_o      (op_d.rs1),
    .rs2_o      (op_d.rs2),
    .start_o    (op_d.start),
    .len_o      (op_d.len),
    .dest_o     (op_d.dest),
    .cmpl_o     (op_d.cmpl),
    .len_zero_o (len_zero)
  );

  cbf_legal #(.XLEN(XLEN)) u_legal (
    .instr_i    (instr_i),
    .start_i    (op_d.start),
    .len_i      (op_d.len),
    .dest_i     (op_d.dest),
    .len_zero_i (len_zero),
    .opc_hit_o  (opc_hit),
    .reserved_o (reserved)
  );

  assign op_d.match   = opc_hit && !reserved;
  assign op_d.illegal = opc_hit && reserved;

  cbf_out_reg u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .op_i    (op_d),
    .valid_o (valid_o),
    .op_o    (op_q)
  );

  assign match_o   = op_q.match;
  assign illegal_o = op_q.illegal;
  assign rd_o      = op_q.rd;
  assign rs1_o     = op_q.rs1;
  assign rs2_o     = op_q.rs2;
  assign start_o   = op_q.start;
  assign len_o     = op_q.len;
  assign dest_o    = op_q.dest;
  assign cmpl_o    = op_q.cmpl;

  p_foreign_opc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[6:0] != CBF_OPCODE) |=> (!match_o && !illegal_o));
  p_reg_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (rd_o[4:3] == 2'b01 && rs1_o[4:3] == 2'b01));
  p_rs2_choice_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (rs2_o == 5'd0 || rs2_o == rd_o));
  p_len_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (len_o != 6'd0 && len_o <= 6'd32));
  p_brownfield_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[6:0] == CBF_OPCODE && (&instr_i[14:12]) && (|instr_i[31:24]))
      |=> illegal_o);
  p_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (({2'b00, start_o} + {2'b00, len_o}) <= LIMIT &&
                 ({2'b00, dest_o} + {2'b00, len_o}) <= LIMIT));
  p_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(match_o && illegal_o));
endmodule

// File: tb/cbf_expander_tb_top.sv
module cbf_expander_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;

  logic       v64, m64, i64, c64, v32, m32, i32, c32;
  logic [4:0] rd64, rs164, rs264, rd32, rs132, rs232;
  logic [5:0] st64, ln64, ds64, st32, ln32, ds32;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cbf_expander #(.XLEN(64)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .valid_o(v64), .match_o(m64), .illegal_o(i64), .rd_o(rd64), .rs1_o(rs164),
    .rs2_o(rs264), .start_o(st64), .len_o(ln64), .dest_o(ds64), .cmpl_o(c64));

  cbf_expander #(.XLEN(32)) dut32_i (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .valid_o(v32), .match_o(m32), .illegal_o(i32), .rd_o(rd32), .rs1_o(rs132),
    .rs2_o(rs232), .start_o(st32), .len_o(ln32), .dest_o(ds32), .cmpl_o(c32));

  function automatic logic [31:0] enc(logic [2:0] rdp, logic [2:0] rs1p, logic rs2s,
                                      logic cm, logic [5:0] st, logic [4:0] lc,
                                      logic [5:0] ds);
    logic [31:0] w;
    w = '0;
    w[6:0]   = 7'b1111011;
    w[9:7]   = rdp;
    w[10]    = rs2s;
    w[11]    = cm;
    w[12]    = lc[4];
    w[13]    = st[4];
    w[14]    = st[5];
    w[17:15] = rs1p;
    w[23:18] = ds;
    w[27:24] = st[3:0];
    w[31:28] = lc[3:0];
    return w;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_one(string req, int xl, logic opc_ok,
                           logic [2:0] rdp, logic [2:0] rs1p, logic rs2s, logic cm,
                           logic [5:0] st, logic [4:0] lc, logic [5:0] ds,
                           int av, int am, int ai, int ard, int ars1, int ars2,
                           int ast, int aln, int ads, int acm);
    int  ln;
    bit  bad;
    bit  em;
    bit  ei;
    ln  = (lc == 0) ? 32 : int'(lc);
    bad = (lc == 0 && xl == 32) ||
          (st[5:4] == 2'b11 && lc[4] && (lc[3:0] != 0 || st[3:0] != 0)) ||
          (int'(st) + ln > xl) || (int'(ds) + ln > xl);
    em = opc_ok && !bad;
    ei = opc_ok && bad;
    chk({req, "/R2"}, $sformatf("valid xlen%0d", xl), av, 1);
    chk(req, $sformatf("match xlen%0d", xl), am, int'(em));
    chk(req, $sformatf("illegal xlen%0d", xl), ai, int'(ei));
    chk("R10", $sformatf("both flags xlen%0d", xl), am & ai, 0);
    if (em) begin
      chk({req, "/R3"}, "rd", ard, int'(rdp) + 8);
      chk({req, "/R3"}, "rs1", ars1, int'(rs1p) + 8);
      chk({req, "/R4"}, "rs2", ars2, rs2s ? int'(rdp) + 8 : 0);
      chk({req, "/R5"}, "start", ast, int'(st));
      chk({req, "/R5"}, "len", aln, ln);
      chk({req, "/R5"}, "dest", ads, int'(ds));
      chk({req, "/R6"}, "cmpl", acm, int'(cm));
    end
  endtask

  task automatic check_both(string req, logic opc_ok, logic [2:0] rdp, logic [2:0] rs1p,
                            logic rs2s, logic cm, logic [5:0] st, logic [4:0] lc,
                            logic [5:0] ds);
    check_one(req, 64, opc_ok, rdp, rs1p, rs2s, cm, st, lc, ds,
              v64, m64, i64, rd64, rs164, rs264, st64, ln64, ds64, c64);
    check_one(req, 32, opc_ok, rdp, rs1p, rs2s, cm, st, lc, ds,
              v32, m32, i32, rd32, rs132, rs232, st32, ln32, ds32, c32);
  endtask

  task automatic run_op(string req, logic [2:0] rdp, logic [2:0] rs1p, logic rs2s,
                        logic cm, logic [5:0] st, logic [4:0] lc, logic [5:0] ds);
    @(negedge clk);
    valid_i = 1'b1;
    instr_i = enc(rdp, rs1p, rs2s, cm, st, lc, ds);
    @(negedge clk);
    valid_i = 1'b0;
    check_both(req, 1'b1, rdp, rs1p, rs2s, cm, st, lc, ds);
  endtask

  task automatic test_reset();
    valid_i = 1'b1;
    instr_i = enc(3'd1, 3'd2, 1'b1, 1'b1, 6'd0, 5'd4, 6'd0);
    repeat (3) @(negedge clk);
    chk("R11", "valid64", v64, 0);
    chk("R11", "match64", m64, 0);
    chk("R11", "rd64", rd64, 0);
    chk("R11", "valid32", v32, 0);
    chk("R11", "len32", ln32, 0);
    valid_i = 1'b0;
    rst_ni  = 1'b1;
  endtask

  task automatic test_idle();
    repeat (2) @(negedge clk);
    chk("R2", "idle valid64", v64, 0);
    chk("R2", "idle flags64", m64 | i64, 0);
    chk("R2", "idle valid32", v32, 0);
  endtask

  task automatic test_foreign_opcode();
    @(negedge clk);
    valid_i = 1'b1;
    instr_i = enc(3'd2, 3'd3, 1'b0, 1'b0, 6'd1, 5'd2, 6'd3) ^ 32'h0000_0004;
    @(negedge clk);
    valid_i = 1'b0;
    check_both("R1", 1'b0, 3'd2, 3'd3, 1'b0, 1'b0, 6'd1, 5'd2, 6'd3);
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    valid_i = 1'b1;
    instr_i = enc(3'd0, 3'd7, 1'b0, 1'b0, 6'd2, 5'd3, 6'd5);
    @(negedge clk);
    instr_i = enc(3'd7, 3'd0, 1'b1, 1'b1, 6'd9, 5'd6, 6'd20);
    check_both("R2", 1'b1, 3'd0, 3'd7, 1'b0, 1'b0, 6'd2, 5'd3, 6'd5);
    @(negedge clk);
    valid_i = 1'b0;
    check_both("R2", 1'b1, 3'd7, 3'd0, 1'b1, 1'b1, 6'd9, 5'd6, 6'd20);
    @(negedge clk);
    chk("R2", "drop valid64", v64, 0);
    chk("R2", "drop flags64", m64 | i64, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_idle();
    run_op("R3", 3'd3, 3'd5, 1'b0, 1'b0, 6'd4, 5'd8, 6'd16);
    run_op("R4", 3'd6, 3'd1, 1'b1, 1'b0, 6'd0, 5'd1, 6'd0);
    run_op("R6", 3'd2, 3'd4, 1'b0, 1'b1, 6'd10, 5'd5, 6'd26);
    run_op("R5", 3'd1, 3'd6, 1'b1, 1'b0, 6'd37, 5'd17, 6'd10);
    run_op("R5", 3'd4, 3'd2, 1'b0, 1'b1, 6'd16, 5'd16, 6'd1);
    run_op("R7", 3'd5, 3'd3, 1'b0, 1'b0, 6'd0, 5'd0, 6'd32);
    run_op("R7", 3'd0, 3'd0, 1'b1, 1'b1, 6'd32, 5'd0, 6'd0);
    run_op("R8", 3'd1, 3'd1, 1'b0, 1'b0, 6'd48, 5'd16, 6'd0);
    run_op("R8", 3'd1, 3'd1, 1'b0, 1'b0, 6'd49, 5'd16, 6'd0);
    run_op("R8", 3'd2, 3'd2, 1'b1, 1'b0, 6'd48, 5'd17, 6'd3);
    run_op("R9", 3'd3, 3'd3, 1'b0, 1'b0, 6'd0, 5'd16, 6'd48);
    run_op("R9", 3'd3, 3'd3, 1'b0, 1'b0, 6'd0, 5'd16, 6'd49);
    run_op("R9", 3'd7, 3'd7, 1'b1, 1'b0, 6'd24, 5'd8, 6'd0);
    run_op("R9", 3'd7, 3'd7, 1'b1, 1'b0, 6'd25, 5'd8, 6'd0);
    run_op("R9", 3'd4, 3'd5, 1'b0, 1'b0, 6'd0, 5'd31, 6'd33);
    test_foreign_opcode();
    test_back_to_back();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule